// File: doc/BRIEF.md
# DSP ALU Condition Code Generator

This block produces the four arithmetic status flags of a DSP data ALU whose results may be 16, 20, 32 or 36 bits wide: negative, zero, overflow and carry. The datapath hands it the raw 36-bit result, the carries into and out of the three possible sign positions, the operation kind, the result size and the destination width. A mode bit that narrows wide results (CC) and a saturation-enable mode bit (SA) shape how the flags are computed. The flags are held in a 4-bit register that loads only on cycles where the datapath asserts the update enable.

Zero detection, overflow/carry extraction and sign selection each sit in their own submodule. The top module holds the flag register. No state machine is needed: the register has a single state, either holding or loading. A synchronous reset clears it.

Top module: `ccgen_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `flags` to 4'b0000.
- R2: While `upd_en` is low, `flags` keeps its value whatever the other inputs do. While `upd_en` is high, the flags computed from the inputs appear on `flags` after the next rising edge.
- R3: Zero flag. The result-size codes are 0=16-bit, 1=20-bit, 2=32-bit and 3=36-bit. The flag is set when all examined bits are zero:
  - size 3: bits 35..0, or bits 31..0 when `mode_cc` is set;
  - size 2: bits 31..0, or bits 15..0 when `dst16` is set;
  - size 1: bits 35..16, or bits 31..16 when `mode_cc` is set;
  - size 0: bits 31..16, or bits 15..0 when `dst16` is set.
- R4: The zero flag does not depend on `mode_sa`.
- R5: Outside integer multiply, and when saturation is not in effect, overflow is `carry_into[k] ^ carry_out[k]`. The taps are k=0 for bit 15, k=1 for bit 31 and k=2 for bit 35. The tap used is:
  - bit 35 for sizes 3 and 1, or bit 31 when `mode_cc` is set;
  - bit 31 for size 2;
  - for size 0, bit 31, or bit 15 when `dst16` is set.
- R6: When `mode_sa` and `sat_hit` are both high and `op_impy` is low, overflow is set.
- R7: When `op_impy` is high, overflow is set exactly when bits 31..15 of the result are not all equal, that is, when the product does not fit in 16 bits. `mode_sa` and `sat_hit` have no effect in this case.
- R8: Carry uses the `carry_out` tap at bit 35 for sizes 3 and 1, at bit 31 for size 2 and at bit 15 for size 0. It is the raw carry on add and its inverse (the borrow) when `is_sub` is high. `mode_cc` and `mode_sa` do not affect it.
- R9: Negative flag:
  - result bit 15 when `dst16` is set;
  - otherwise bit 31 for sizes 2 and 0;
  - otherwise bit 35, or bit 31 when `mode_cc` is set.
- R10: When `op_asll` and `mode_cc` are both high, the negative flag is 0.
- R11: Flag positions in `flags` are carry at bit 0, overflow at bit 1, zero at bit 2 and negative at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Load computed flags this cycle |
| result | input | 36 | Raw ALU result |
| carry_into | input | 3 | Carry into bit 15 / 31 / 35 (index 0 / 1 / 2) |
| carry_out | input | 3 | Raw adder carry out of bit 15 / 31 / 35 |
| is_sub | input | 1 | Operation is a subtraction |
| res_size | input | 2 | Result size code (0=16, 1=20, 2=32, 3=36) |
| dst16 | input | 1 | Destination is a 16-bit register |
| sat_hit | input | 1 | Output limiter saturated |
| op_impy | input | 1 | Integer multiply operation |
| op_asll | input | 1 | Long arithmetic left shift operation |
| mode_cc | input | 1 | Narrow wide results to 32/16 bits |
| mode_sa | input | 1 | Saturation mode enabled |
| flags | output | 4 | Registered flags {N, Z, V, C} |

## Verification
The assertions assume that `rst` is high at the first rising edge. They also assume that every input is settled for the whole clock cycle, so a property sampled at one edge sees the values that produced the next register load. The saturation property further assumes that the datapath never reports integer multiply together with saturation in a way that would conflict with R7, and its antecedent excludes `op_impy` for that reason. The bench changes all inputs only on the falling edge, and it holds reset for several edges before releasing it.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;
    localparam int RES_W  = 36;
    localparam int FLAG_W = 4;
    localparam int TAP_N  = 3;

    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_20 = 2'd1,
        SZ_32 = 2'd2,
        SZ_36 = 2'd3
    } res_size_e;

    typedef enum logic [1:0] {
        TAP_B15 = 2'd0,
        TAP_B31 = 2'd1,
        TAP_B35 = 2'd2
    } tap_e;
endpackage

// File: rtl/ccgen_zero.sv
module ccgen_zero
    import ccgen_pkg::*;
(
    input  logic [RES_W-1:0] result,
    input  res_size_e        size,
    input  logic             dst16,
    input  logic             mode_cc,
    output logic             zero
);
    localparam logic [RES_W-1:0] M_LO16 = RES_W'(36'h0_0000_FFFF);
    localparam logic [RES_W-1:0] M_HI16 = RES_W'(36'h0_FFFF_0000);
    localparam logic [RES_W-1:0] M_W32  = RES_W'(36'h0_FFFF_FFFF);
    localparam logic [RES_W-1:0] M_W36  = {RES_W{1'b1}};
    localparam logic [RES_W-1:0] M_W20  = RES_W'(36'hF_FFFF_0000);

    logic [RES_W-1:0] mask;

    always_comb begin
        unique case (size)
            SZ_36:   mask = mode_cc ? M_W32  : M_W36;
            SZ_32:   mask = dst16   ? M_LO16 : M_W32;
            SZ_20:   mask = mode_cc ? M_HI16 : M_W20;
            default: mask = dst16   ? M_LO16 : M_HI16;
        endcase
        zero = ~|(result & mask);
    end
endmodule

// File: rtl/ccgen_arith.sv
module ccgen_arith
    import ccgen_pkg::*;
(
    input  logic [RES_W-1:0] result,
    input  logic [TAP_N-1:0] carry_into,
    input  logic [TAP_N-1:0] carry_out,
    input  logic             is_sub,
    input  res_size_e        size,
    input  logic             dst16,
    input  logic             mode_cc,
    input  logic             mode_sa,
    input  logic             sat_hit,
    input  logic             op_impy,
    output logic             ovf,
    output logic             cry
);
    tap_e v_tap;
    tap_e c_tap;
    logic impy_wide;

    always_comb begin
        unique case (size)
            SZ_36, SZ_20: v_tap = mode_cc ? TAP_B31 : TAP_B35;
            SZ_32:        v_tap = TAP_B31;
            default:      v_tap = dst16 ? TAP_B15 : TAP_B31;
        endcase
        unique case (size)
            SZ_36, SZ_20: c_tap = TAP_B35;
            SZ_32:        c_tap = TAP_B31;
            default:      c_tap = TAP_B15;
        endcase
    end

    // product fits in 16 bits only if bits 31..15 are a sign extension
    assign impy_wide = ~((&result[31:15]) | ~(|result[31:15]));

    always_comb begin
        if (op_impy)
            ovf = impy_wide;
        else if (mode_sa && sat_hit)
            ovf = 1'b1;
        else
            ovf = carry_into[v_tap] ^ carry_out[v_tap];
        cry = carry_out[c_tap] ^ is_sub;
    end
endmodule

// File: rtl/ccgen_sign.sv
module ccgen_sign
    import ccgen_pkg::*;
(
    input  logic [RES_W-1:0] result,
    input  res_size_e        size,
    input  logic             dst16,
    input  logic             mode_cc,
    input  logic             op_asll,
    output logic             neg
);
    logic raw;

    always_comb begin
        if (dst16)
            raw = result[15];
        else if (size == SZ_32 || size == SZ_16)
            raw = result[31];
        else
            raw = mode_cc ? result[31] : result[35];
        neg = raw & ~(op_asll & mode_cc);
    end
endmodule

// File: rtl/ccgen_top.sv
module ccgen_top
    import ccgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [35:0]       result,
    input  logic [2:0]        carry_into,
    input  logic [2:0]        carry_out,
    input  logic              is_sub,
    input  logic [1:0]        res_size,
    input  logic              dst16,
    input  logic              sat_hit,
    input  logic              op_impy,
    input  logic              op_asll,
    input  logic              mode_cc,
    input  logic              mode_sa,
    output logic [3:0]        flags
);
    res_size_e         size;
    logic              z_d, v_d, c_d, n_d;
    logic [FLAG_W-1:0] flags_d;
    logic [FLAG_W-1:0] flags_q;

    assign size = res_size_e'(res_size);

    ccgen_zero u_zero (
        .result (result), .size (size), .dst16 (dst16),
        .mode_cc (mode_cc), .zero (z_d)
    );

    ccgen_arith u_arith (
        .result (result), .carry_into (carry_into), .carry_out (carry_out),
        .is_sub (is_sub), .size (size), .dst16 (dst16), .mode_cc (mode_cc),
        .mode_sa (mode_sa), .sat_hit (sat_hit), .op_impy (op_impy),
        .ovf (v_d), .cry (c_d)
    );

    ccgen_sign u_sign (
        .result (result), .size (size), .dst16 (dst16),
        .mode_cc (mode_cc), .op_asll (op_asll), .neg (n_d)
    );

    always_comb begin
        flags_d        = '0;
        flags_d[FLG_C] = c_d;
        flags_d[FLG_V] = v_d;
        flags_d[FLG_Z] = z_d;
        flags_d[FLG_N] = n_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (upd_en)
            flags_q <= flags_d;
    end

    assign flags = flags_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> flags_q == '0);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(flags_q));

    p_zero_full_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && res_size == 2'd3 && !mode_cc && result == '0) |=> flags_q[FLG_Z]);

    p_sat_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && mode_sa && sat_hit && !op_impy) |=> flags_q[FLG_V]);

    p_impy_fits_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_impy && result[31:15] == '0) |=> !flags_q[FLG_V]);

    p_asll_neg_r10: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_asll && mode_cc) |=> !flags_q[FLG_N]);
endmodule

// File: tb/test_ccgen_top.sv
module test_ccgen_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_en = 1'b0;
    logic [35:0] result = '0;
    logic [2:0]  carry_into = '0;
    logic [2:0]  carry_out = '0;
    logic        is_sub = 1'b0;
    logic [1:0]  res_size = 2'd0;
    logic        dst16 = 1'b0;
    logic        sat_hit = 1'b0;
    logic        op_impy = 1'b0;
    logic        op_asll = 1'b0;
    logic        mode_cc = 1'b0;
    logic        mode_sa = 1'b0;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccgen_top i_ccgen_top (
        .clk (clk), .rst (rst), .upd_en (upd_en), .result (result),
        .carry_into (carry_into), .carry_out (carry_out), .is_sub (is_sub),
        .res_size (res_size), .dst16 (dst16), .sat_hit (sat_hit),
        .op_impy (op_impy), .op_asll (op_asll), .mode_cc (mode_cc),
        .mode_sa (mode_sa), .flags (flags)
    );

    function automatic logic exp_z();
        case (res_size)
            2'd3:    return mode_cc ? (result[31:0] == 0) : (result == 0);
            2'd2:    return dst16 ? (result[15:0] == 0) : (result[31:0] == 0);
            2'd1:    return mode_cc ? (result[31:16] == 0) : (result[35:16] == 0);
            default: return dst16 ? (result[15:0] == 0) : (result[31:16] == 0);
        endcase
    endfunction

    function automatic logic exp_v();
        int k;
        if (op_impy) return result[31:15] != {17{result[31]}};
        if (mode_sa && sat_hit) return 1'b1;
        if (res_size == 2'd0) k = dst16 ? 0 : 1;
        else if (res_size == 2'd2) k = 1;
        else k = mode_cc ? 1 : 2;
        return carry_into[k] != carry_out[k];
    endfunction

    function automatic logic exp_c();
        int k;
        k = (res_size == 2'd0) ? 0 : (res_size == 2'd2) ? 1 : 2;
        return is_sub ? !carry_out[k] : carry_out[k];
    endfunction

    function automatic logic exp_n();
        if (op_asll && mode_cc) return 1'b0;
        if (dst16) return result[15];
        if (res_size == 2'd2 || res_size == 2'd0) return result[31];
        return mode_cc ? result[31] : result[35];
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flags=%b expected=%b", req, act, exp);
        end
    endtask

    // drive on falling edge, flags load at next rising edge, sample at next falling edge
    task automatic step_and_check(input string req);
        logic [3:0] e;
        e = {exp_n(), exp_z(), exp_v(), exp_c()};
        upd_en = 1'b1;
        @(negedge clk);
        check(req, flags, e);
    endtask

    task automatic clear_ins();
        result = '0; carry_into = '0; carry_out = '0; is_sub = 0; res_size = 0;
        dst16 = 0; sat_hit = 0; op_impy = 0; op_asll = 0; mode_cc = 0; mode_sa = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset", flags, 4'b0000);
        rst = 1'b0;

        // R3 R11: 36-bit, bits above 31 only: Z depends on CC
        clear_ins(); res_size = 2'd3; result = 36'h1_0000_0000; mode_cc = 1;
        step_and_check("R3 R11 zero 36 cc");
        mode_cc = 0;
        step_and_check("R3 zero 36 no cc");
        // R3: 20-bit sees only upper field
        res_size = 2'd1; result = 36'h0_0000_FFFF;
        step_and_check("R3 zero 20");
        // R4: SA toggled with same result
        mode_sa = 1;
        step_and_check("R4 zero ignores sa");
        // R6: saturation forces V
        clear_ins(); res_size = 2'd3; result = 36'h7_FFFF_FFFF; mode_sa = 1; sat_hit = 1;
        step_and_check("R6 sat overflow");
        mode_sa = 0;
        step_and_check("R5 no sa no carry mismatch");
        // R5: CC moves the tap to bit 31
        carry_into = 3'b010; mode_cc = 1;
        step_and_check("R5 cc tap 31");
        // R7: impy fits, SA ignored
        clear_ins(); op_impy = 1; mode_sa = 1; sat_hit = 1; result = 36'h0_0000_7FFF;
        step_and_check("R7 impy fits");
        result = 36'h0_0000_8000;
        step_and_check("R7 impy too wide");
        // R8: borrow at bit 35
        clear_ins(); res_size = 2'd1; is_sub = 1; carry_out = 3'b011;
        step_and_check("R8 borrow 35");
        // R9 R10: ASLL under CC clears N
        clear_ins(); res_size = 2'd3; result = 36'hF_FFFF_FFFF; mode_cc = 1; op_asll = 1;
        step_and_check("R10 asll cc");
        op_asll = 0; dst16 = 1; result = 36'h0_0000_8000;
        step_and_check("R9 neg dst16");

        // R2: hold while upd_en low
        held = flags;
        upd_en = 0; result = 36'h0; carry_out = 3'b111; mode_sa = 1; sat_hit = 1;
        @(negedge clk); @(negedge clk);
        check("R2 hold", flags, held);

        for (int i = 0; i < 3000; i++) begin
            result     = {4'($urandom), 32'($urandom)};
            if (($urandom % 4) == 0) result = result & 36'h0_0000_FFFF;
            if (($urandom % 4) == 0) result = result & 36'hF_0000_FFFF;
            carry_into = 3'($urandom);
            carry_out  = 3'($urandom);
            is_sub     = 1'($urandom);
            res_size   = 2'($urandom);
            dst16      = 1'($urandom);
            sat_hit    = 1'($urandom);
            op_impy    = (($urandom % 5) == 0);
            op_asll    = (($urandom % 4) == 0);
            mode_cc    = 1'($urandom);
            mode_sa    = 1'($urandom);
            step_and_check("R3 R5 R6 R7 R8 R9 R10 random");
        end

        rst = 1;
        @(negedge clk);
        check("R1 reset again", flags, 4'b0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule